// File: doc/BRIEF.md
# VF routing ID decoder

This block resolves 8-bit bus routing IDs (device and function number) against the virtual functions of one physical function. Configuration inputs give the physical function's own routing ID, the distance from it to the first virtual function, the spacing between neighbouring virtual functions, the number of virtual functions built in, the number software has asked for, and whether virtual functions are switched on. From these the decoder works out addresses by arithmetic. It keeps no table.

A lookup routing ID presented with a valid strobe is mapped back to a virtual function index. One cycle later the decoder reports a hit flag, the index, the owning physical function's routing ID, and the all-ones identity word that a virtual function shows in place of its vendor and device IDs. A combinational forward port turns an index into its routing ID. A configuration-error flag is raised when the programmed layout cannot exist in the 8-bit routing space.

Top module: `vf_rid_decoder`

## Requirements
- R1: The forward port gives `fwd_rid` = (pf_rid + vf_offset + fwd_idx * vf_stride) mod 256. `fwd_hit` is 1 exactly when fwd_idx is below the active count.
- R2: When total_vfs is nonzero and pf_rid + vf_offset + (total_vfs - 1) * vf_stride is 256 or more, `cfg_err` is 1. A last address of 255 or less is not an error.
- R3: When total_vfs is nonzero and vf_offset is 0, `cfg_err` is 1, because the first VF must sit strictly above the physical function.
- R4: While `cfg_err` is 1, neither the forward port nor a reverse lookup reports a hit.
- R5: A reverse lookup with `lk_valid` = 1 hits when lk_rid - pf_rid - vf_offset is non-negative, divisible by a nonzero stride, and its quotient is below the active count. The quotient is returned on `rev_index`. The result appears on the clock edge after the lookup is presented.
- R6: With vf_stride = 0, only the first VF address hits, always with index 0, provided the active count is at least 1.
- R7: With `vf_enable` = 0 the active count is 0, so no lookup hits, whatever num_vfs holds.
- R8: The active count is the smaller of num_vfs and total_vfs. An index at or above it misses on both ports.
- R9: IDs below the first VF address, or off the stride grid, miss.
- R10: On a reverse hit, `rev_pf_rid` equals the pf_rid presented with the lookup and `rev_id_word` is 32'hFFFF_FFFF. On a miss both are 0, and `rev_index` is 0.
- R11: Synchronous active-high reset clears all registered outputs. A cycle with `lk_valid` = 0 gives `rev_hit` = 0 on the next edge.
- R12: With total_vfs = 0 there is no configuration error and nothing hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_rid | input | 8 | Routing ID of the physical function |
| vf_offset | input | 16 | Distance from the physical function to the first VF |
| vf_stride | input | 16 | Distance between neighbouring VFs |
| total_vfs | input | 16 | Number of VFs built in |
| num_vfs | input | 16 | Number of VFs requested by software |
| vf_enable | input | 1 | VFs switched on |
| lk_valid | input | 1 | Reverse lookup strobe |
| lk_rid | input | 8 | Routing ID to resolve |
| fwd_idx | input | 16 | VF index for the forward query |
| cfg_err | output | 1 | Layout invalid (combinational) |
| rev_hit | output | 1 | Registered reverse-lookup hit |
| rev_index | output | 16 | Registered VF index of the hit |
| rev_pf_rid | output | 8 | Registered owner routing ID of the hit |
| rev_id_word | output | 32 | Registered identity word seen for the VF |
| fwd_hit | output | 1 | Forward index is active (combinational) |
| fwd_rid | output | 8 | Routing ID of fwd_idx (combinational) |

## Verification
`cfg_err`, `fwd_hit` and `fwd_rid` follow the inputs within the same cycle. Every reverse-lookup output is due on the first rising edge after the lookup is presented. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples all outputs on the next falling edge. At that point the combinational results still reflect the same inputs and the registered results reflect that single edge. The reset and strobe-low checks use the same one-edge spacing.

// File: rtl/vfdec_pkg.sv
package vfdec_pkg;

    parameter int RID_W = 8;
    parameter int FLD_W = 16;

    localparam int SPAN_W    = 2 * FLD_W + 2;
    localparam int RID_SPACE = 1 << RID_W;
    localparam int WORD_W    = 32;

    typedef logic [RID_W-1:0]  rid_t;
    typedef logic [FLD_W-1:0]  fld_t;
    typedef logic [SPAN_W-1:0] span_t;

    localparam logic [WORD_W-1:0] VF_ID_WORD = '1;

    typedef struct packed {
        logic              hit;
        fld_t              index;
        rid_t              pf_rid;
        logic [WORD_W-1:0] id_word;
    } rev_res_t;

    typedef struct packed {
        rid_t quo;
        rid_t rem;
    } divres_t;

    // Restoring division of a routing distance by the stride, one bit per step.
    function automatic divres_t rid_divide(rid_t num, fld_t den);
        logic [FLD_W:0] acc;
        divres_t        r;
        acc = '0;
        r   = '0;
        for (int b = RID_W - 1; b >= 0; b--) begin
            acc = {acc[FLD_W-1:0], num[b]};
            if (acc >= {1'b0, den}) begin
                acc      = acc - {1'b0, den};
                r.quo[b] = 1'b1;
            end
        end
        r.rem = acc[RID_W-1:0];
        return r;
    endfunction

    // Full-precision routing address of VF number idx.
    function automatic span_t vf_span(rid_t pf, fld_t off, fld_t stride, fld_t idx);
        return span_t'(pf) + span_t'(off) + span_t'(idx) * span_t'(stride);
    endfunction

endpackage

// File: rtl/vfdec_cfg_check.sv
module vfdec_cfg_check
    import vfdec_pkg::*;
(
    input  logic rst,
    input  rid_t pf_rid,
    input  fld_t vf_offset,
    input  fld_t vf_stride,
    input  fld_t total_vfs,
    input  fld_t num_vfs,
    input  logic vf_enable,
    output logic cfg_err,
    output fld_t active_cnt
);

    span_t last_addr;
    logic  populated;
    logic  overflow;
    logic  zero_gap;
    fld_t  capped;

    assign populated = (total_vfs != '0);
    assign last_addr = vf_span(pf_rid, vf_offset, vf_stride,
                               populated ? (total_vfs - fld_t'(1)) : '0);
    assign overflow  = populated && (last_addr >= span_t'(RID_SPACE));
    assign zero_gap  = populated && (vf_offset == '0);
    assign cfg_err   = overflow | zero_gap;

    assign capped     = (num_vfs < total_vfs) ? num_vfs : total_vfs;
    assign active_cnt = (vf_enable && !cfg_err) ? capped : '0;

    always_comb begin
        if (!rst) begin
            assert_active_capped_R8: assert (active_cnt <= total_vfs && active_cnt <= num_vfs);
            assert_empty_clean_R12:  assert (total_vfs != '0 || (!cfg_err && active_cnt == '0));
        end
    end

endmodule

// File: rtl/vfdec_forward.sv
module vfdec_forward
    import vfdec_pkg::*;
(
    input  logic rst,
    input  rid_t pf_rid,
    input  fld_t vf_offset,
    input  fld_t vf_stride,
    input  fld_t active_cnt,
    input  fld_t fwd_idx,
    output logic fwd_hit,
    output rid_t fwd_rid
);

    span_t addr;

    assign addr    = vf_span(pf_rid, vf_offset, vf_stride, fwd_idx);
    assign fwd_hit = (fwd_idx < active_cnt);
    assign fwd_rid = addr[RID_W-1:0];

    // An active index must land inside the routing space without wrapping.
    always_comb begin
        if (!rst) begin
            assert_fwd_in_space_R2: assert (!fwd_hit || addr < span_t'(RID_SPACE));
        end
    end

endmodule

// File: rtl/vfdec_reverse.sv
module vfdec_reverse
    import vfdec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rid_t     pf_rid,
    input  fld_t     vf_offset,
    input  fld_t     vf_stride,
    input  fld_t     active_cnt,
    input  logic     lk_valid,
    input  rid_t     lk_rid,
    output rev_res_t res_q
);

    span_t   base;
    logic    above;
    rid_t    delta;
    divres_t dv;
    logic    on_grid;
    fld_t    cand_idx;
    logic    cand_hit;

    assign base  = span_t'(pf_rid) + span_t'(vf_offset);
    assign above = (span_t'(lk_rid) >= base);
    assign delta = lk_rid - base[RID_W-1:0];
    assign dv    = rid_divide(delta, vf_stride);

    always_comb begin
        if (vf_stride == '0) begin
            on_grid  = (delta == '0);
            cand_idx = '0;
        end else begin
            on_grid  = (dv.rem == '0);
            cand_idx = fld_t'(dv.quo);
        end
        cand_hit = above && on_grid && (cand_idx < active_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (lk_valid && cand_hit) begin
            res_q.hit     <= 1'b1;
            res_q.index   <= cand_idx;
            res_q.pf_rid  <= pf_rid;
            res_q.id_word <= VF_ID_WORD;
        end else begin
            res_q <= '0;
        end
    end

    assert_idx_active_R8: assert property (@(posedge clk) disable iff (rst)
        res_q.hit |-> (res_q.index < $past(active_cnt)));
    assert_stride0_first_R6: assert property (@(posedge clk) disable iff (rst)
        (res_q.hit && $past(vf_stride) == '0) |-> (res_q.index == '0));
    assert_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_q.hit);
    assert_owner_id_R10: assert property (@(posedge clk) disable iff (rst)
        res_q.hit |-> (res_q.pf_rid == $past(pf_rid)));

endmodule

// File: rtl/vf_rid_decoder.sv
module vf_rid_decoder
    import vfdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RID_W-1:0]  pf_rid,
    input  logic [FLD_W-1:0]  vf_offset,
    input  logic [FLD_W-1:0]  vf_stride,
    input  logic [FLD_W-1:0]  total_vfs,
    input  logic [FLD_W-1:0]  num_vfs,
    input  logic              vf_enable,
    input  logic              lk_valid,
    input  logic [RID_W-1:0]  lk_rid,
    input  logic [FLD_W-1:0]  fwd_idx,
    output logic              cfg_err,
    output logic              rev_hit,
    output logic [FLD_W-1:0]  rev_index,
    output logic [RID_W-1:0]  rev_pf_rid,
    output logic [WORD_W-1:0] rev_id_word,
    output logic              fwd_hit,
    output logic [RID_W-1:0]  fwd_rid
);

    fld_t     active_cnt;
    rev_res_t res;

    vfdec_cfg_check u_cfg (
        .rst        (rst),
        .pf_rid     (pf_rid),
        .vf_offset  (vf_offset),
        .vf_stride  (vf_stride),
        .total_vfs  (total_vfs),
        .num_vfs    (num_vfs),
        .vf_enable  (vf_enable),
        .cfg_err    (cfg_err),
        .active_cnt (active_cnt)
    );

    vfdec_forward u_fwd (
        .rst        (rst),
        .pf_rid     (pf_rid),
        .vf_offset  (vf_offset),
        .vf_stride  (vf_stride),
        .active_cnt (active_cnt),
        .fwd_idx    (fwd_idx),
        .fwd_hit    (fwd_hit),
        .fwd_rid    (fwd_rid)
    );

    vfdec_reverse u_rev (
        .clk        (clk),
        .rst        (rst),
        .pf_rid     (pf_rid),
        .vf_offset  (vf_offset),
        .vf_stride  (vf_stride),
        .active_cnt (active_cnt),
        .lk_valid   (lk_valid),
        .lk_rid     (lk_rid),
        .res_q      (res)
    );

    assign rev_hit     = res.hit;
    assign rev_index   = res.index;
    assign rev_pf_rid  = res.pf_rid;
    assign rev_id_word = res.id_word;

    assert_err_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        rev_hit |-> !$past(cfg_err));
    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (rst)
        rev_hit |-> $past(vf_enable));

endmodule

// File: tb/sim_vf_rid_decoder.sv
`timescale 1ns/1ps
module sim_vf_rid_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pf_rid = '0;
    logic [15:0] vf_offset = '0, vf_stride = '0, total_vfs = '0, num_vfs = '0, fwd_idx = '0;
    logic        vf_enable = 1'b0, lk_valid = 1'b0;
    logic [7:0]  lk_rid = '0;
    logic        cfg_err, rev_hit, fwd_hit;
    logic [15:0] rev_index;
    logic [7:0]  rev_pf_rid, fwd_rid;
    logic [31:0] rev_id_word;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vf_rid_decoder u0 (
        .clk(clk), .rst(rst), .pf_rid(pf_rid), .vf_offset(vf_offset),
        .vf_stride(vf_stride), .total_vfs(total_vfs), .num_vfs(num_vfs),
        .vf_enable(vf_enable), .lk_valid(lk_valid), .lk_rid(lk_rid),
        .fwd_idx(fwd_idx), .cfg_err(cfg_err), .rev_hit(rev_hit),
        .rev_index(rev_index), .rev_pf_rid(rev_pf_rid), .rev_id_word(rev_id_word),
        .fwd_hit(fwd_hit), .fwd_rid(fwd_rid)
    );

    typedef struct packed {
        logic [7:0]  pf;
        logic [15:0] off;
        logic [15:0] str;
        logic [15:0] tot;
        logic [15:0] num;
        logic        en;
        logic [7:0]  rid;
        logic        ehit;
        logic [15:0] eidx;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{8'd8,   16'd1,  16'd1,   16'd4, 16'd4, 1'b1, 8'd9,   1'b1, 16'd0, 1'b0, 4'd5},
        '{8'd8,   16'd1,  16'd1,   16'd4, 16'd4, 1'b1, 8'd12,  1'b1, 16'd3, 1'b0, 4'd5},
        '{8'd8,   16'd1,  16'd1,   16'd4, 16'd4, 1'b1, 8'd13,  1'b0, 16'd0, 1'b0, 4'd8},
        '{8'd8,   16'd2,  16'd2,   16'd8, 16'd5, 1'b1, 8'd16,  1'b1, 16'd3, 1'b0, 4'd5},
        '{8'd8,   16'd2,  16'd2,   16'd8, 16'd5, 1'b1, 8'd17,  1'b0, 16'd0, 1'b0, 4'd9},
        '{8'd8,   16'd2,  16'd2,   16'd8, 16'd5, 1'b1, 8'd20,  1'b0, 16'd0, 1'b0, 4'd8},
        '{8'd8,   16'd2,  16'd2,   16'd8, 16'd5, 1'b1, 8'd9,   1'b0, 16'd0, 1'b0, 4'd9},
        '{8'd16,  16'd4,  16'd0,   16'd3, 16'd3, 1'b1, 8'd20,  1'b1, 16'd0, 1'b0, 4'd6},
        '{8'd16,  16'd4,  16'd0,   16'd3, 16'd3, 1'b1, 8'd21,  1'b0, 16'd0, 1'b0, 4'd6},
        '{8'd0,   16'd1,  16'd1,   16'd4, 16'd4, 1'b0, 8'd2,   1'b0, 16'd0, 1'b0, 4'd7},
        '{8'd200, 16'd50, 16'd2,   16'd4, 16'd4, 1'b1, 8'd250, 1'b0, 16'd0, 1'b1, 4'd4},
        '{8'd200, 16'd50, 16'd2,   16'd3, 16'd3, 1'b1, 8'd254, 1'b1, 16'd2, 1'b0, 4'd2},
        '{8'd5,   16'd0,  16'd1,   16'd2, 16'd2, 1'b1, 8'd5,   1'b0, 16'd0, 1'b1, 4'd3},
        '{8'd0,   16'd3,  16'd300, 16'd1, 16'd1, 1'b1, 8'd3,   1'b1, 16'd0, 1'b0, 4'd5},
        '{8'd0,   16'd1,  16'd1,   16'd2, 16'd5, 1'b1, 8'd3,   1'b0, 16'd0, 1'b0, 4'd8},
        '{8'd0,   16'd0,  16'd0,   16'd0, 16'd0, 1'b1, 8'd0,   1'b0, 16'd0, 1'b0, 4'd12}
    };

    function automatic string tag_of(logic [3:0] n);
        case (n)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(vec_t v, logic strobe, logic [15:0] fi);
        pf_rid    = v.pf;
        vf_offset = v.off;
        vf_stride = v.str;
        total_vfs = v.tot;
        num_vfs   = v.num;
        vf_enable = v.en;
        lk_rid    = v.rid;
        lk_valid  = strobe;
        fwd_idx   = fi;
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 reset hit", 64'(rev_hit), 64'd0);
        chk("R11 reset index", 64'(rev_index), 64'd0);
        chk("R11 reset word", 64'(rev_id_word), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            @(negedge clk);
            apply(v, 1'b1, v.eidx);
            @(negedge clk);
            chk(v.tot == 0 ? "R12" : (v.off == 0 ? "R3" : "R2"), 64'(cfg_err), 64'(v.eerr));
            chk(tag_of(v.req), 64'(rev_hit), 64'(v.ehit));
            chk("R10 index", 64'(rev_index), 64'(v.eidx));
            if (v.ehit) begin
                chk("R10 owner", 64'(rev_pf_rid), 64'(v.pf));
                chk("R10 word", 64'(rev_id_word), 64'hFFFF_FFFF);
                chk("R1 fwd hit", 64'(fwd_hit), 64'd1);
                chk("R1 fwd rid", 64'(fwd_rid), 64'(v.rid));
            end else begin
                chk("R10 miss word", 64'(rev_id_word), 64'd0);
                chk("R10 miss owner", 64'(rev_pf_rid), 64'd0);
            end
            if (v.eerr) chk("R4 fwd blocked", 64'(fwd_hit), 64'd0);
        end

        // R11: strobe low with a matching ID gives no hit
        @(negedge clk);
        apply(TBL[0], 1'b0, 16'd0);
        @(negedge clk);
        chk("R11 no strobe", 64'(rev_hit), 64'd0);

        // R1 / R8: forward arithmetic at the last active index and one past it
        apply(TBL[3], 1'b0, 16'd4);
        #1;
        chk("R1 fwd idx4 hit", 64'(fwd_hit), 64'd1);
        chk("R1 fwd idx4 rid", 64'(fwd_rid), 64'd18);
        fwd_idx = 16'd5;
        #1;
        chk("R8 fwd idx5 miss", 64'(fwd_hit), 64'd0);

        // R7: enable off blocks the forward port too
        vf_enable = 1'b0;
        fwd_idx   = 16'd0;
        #1;
        chk("R7 fwd disabled", 64'(fwd_hit), 64'd0);

        // R11: reset after a hit clears outputs
        @(negedge clk);
        apply(TBL[1], 1'b1, 16'd0);
        @(negedge clk);
        chk("R5 pre-reset hit", 64'(rev_hit), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 reset clears", 64'(rev_hit), 64'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule